// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence for a single SDRAM read or write burst. A column command loads it with an 8-bit starting column, a burst length code and an ordering choice. From the next cycle on it presents one column per clock. It stops when the fixed length is used up, when a burst-stop command arrives, or when a newer column command replaces the burst.

Two orderings are supported. Sequential ordering counts upward inside the aligned block that the burst length defines and wraps within it. Interleaved ordering XORs the start column with the beat number. A full-page mode runs through all 256 columns, wraps from the top column to zero, and continues until it is stopped or replaced. Full page is only accepted with sequential ordering. A command that asks for an illegal combination is dropped.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and afterwards until the first accepted command, `busy` and `lastBeat` are 0 and `colAddr` is 0.
- R2: A legal command sampled on a rising edge makes `busy` 1 and `colAddr` equal to `startCol` in the following cycle. `lenCode` values 0 to 3 select bursts of 1, 2, 4 or 8 beats. Value 7 selects full page. `ilvOrder` 0 means sequential and 1 means interleaved.
- R3: In sequential order, beat n of a burst of length BL shows `(startCol & ~(BL-1)) | ((startCol + n) & (BL-1))`.
- R4: In interleaved order, beat n shows `startCol ^ n`.
- R5: A fixed-length burst lasts exactly BL beats. `lastBeat` is 1 on the final beat only, and `busy` is 0 in the cycle after the final beat unless a new command arrives.
- R6: In full-page mode, each beat shows the previous column plus one modulo 256, so 255 is followed by 0. The burst never ends on its own and `lastBeat` stays 0.
- R7: When `stopCmd` is sampled without a command, `busy` is 0 and `colAddr` is 0 in the next cycle.
- R8: A legal command restarts the generator on any cycle, including the final beat. It takes priority over a simultaneous `stopCmd`.
- R9: A command with `lenCode` 4, 5 or 6, or with full page and interleaved order, is ignored. An idle generator stays idle, and a running burst continues its sequence unchanged.
- R10: `lastBeat` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Column command (read or write) issued this cycle |
| startCol | input | 8 | Starting column of the command |
| lenCode | input | 3 | Burst length code: 0..3 for 1/2/4/8 beats, 7 for full page |
| ilvOrder | input | 1 | 0 sequential, 1 interleaved |
| stopCmd | input | 1 | Burst-stop command issued this cycle |
| colAddr | output | 8 | Column of the current beat, 0 when idle |
| lastBeat | output | 1 | Final beat of a fixed-length burst |
| busy | output | 1 | A burst is in progress |

## Verification
Every result appears one register stage after the command that causes it. A command sampled at edge k shows beat 0 from edge k onward and beat n after edge k+n. A stop sampled at edge k clears `busy` after that same edge. The bench drives inputs on falling edges and checks outputs on the next falling edge, half a period after the edge that updates them. Beat n is therefore checked n+1 falling edges after the command is driven. The sweeps cover every start column with every fixed length and both orders, so each wrap point inside an aligned block is reached.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  // Length code that selects an unbounded (full-page) burst.
  localparam logic [2:0] LEN_FULL = 3'd7;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic load;     // capture a new burst configuration
    logic advance;  // step to the next beat
  } dpStrobe_t;
endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int unsigned LEN_W      = 3,
  parameter int unsigned MAX_LOG_BL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             ilvOrder,
  input  logic             stopCmd,
  input  logic             atEnd,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             lastBeat
);
  logic isFixed;
  logic isFull;
  logic cmdLegal;
  logic accept;

  assign isFixed  = (lenCode <= LEN_W'(MAX_LOG_BL));
  assign isFull   = (lenCode == LEN_W'(LEN_FULL)) && !ilvOrder;
  assign cmdLegal = isFixed || isFull;
  assign accept   = cmdValid && cmdLegal;

  assign strobe.load    = accept;
  assign strobe.advance = busy && !accept;
  assign lastBeat       = busy && atEnd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
    end else if (stopCmd || lastBeat) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8,
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             ilvOrder,
  output logic [COL_W-1:0] nextCol,
  output logic             atEnd
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  logic [COL_W-1:0] startReg;
  logic [COL_W-1:0] maskReg;
  logic [COL_W-1:0] beatCnt;
  logic             ilvReg;
  logic             fullReg;
  logic [COL_W-1:0] loadMask;
  logic             loadFull;
  logic [COL_W-1:0] seqCol;

  assign loadFull = (lenCode == LEN_W'(LEN_FULL));
  assign loadMask = loadFull ? ALL_ONES : ((COL_W'(1) << lenCode) - COL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startReg <= '0;
      maskReg  <= '0;
      beatCnt  <= '0;
      ilvReg   <= 1'b0;
      fullReg  <= 1'b0;
    end else if (strobe.load) begin
      startReg <= startCol;
      maskReg  <= loadMask;
      beatCnt  <= '0;
      ilvReg   <= ilvOrder;
      fullReg  <= loadFull;
    end else if (strobe.advance) begin
      beatCnt  <= beatCnt + COL_W'(1);
    end
  end

  assign seqCol  = (startReg & ~maskReg) | ((startReg + beatCnt) & maskReg);
  assign nextCol = ilvReg ? (startReg ^ beatCnt) : seqCol;
  assign atEnd   = !fullReg && (beatCnt == maskReg);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W      = 8,
  parameter int unsigned LEN_W      = 3,
  parameter int unsigned MAX_LOG_BL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             ilvOrder,
  input  logic             stopCmd,
  output logic [COL_W-1:0] colAddr,
  output logic             lastBeat,
  output logic             busy
);
  dpStrobe_t        strobe;
  logic             atEnd;
  logic [COL_W-1:0] dpCol;

  burst_col_ctrl #(.LEN_W(LEN_W), .MAX_LOG_BL(MAX_LOG_BL)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .lenCode(lenCode),
    .ilvOrder(ilvOrder), .stopCmd(stopCmd), .atEnd(atEnd),
    .strobe(strobe), .busy(busy), .lastBeat(lastBeat)
  );

  burst_col_dp #(.COL_W(COL_W), .LEN_W(LEN_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .startCol(startCol),
    .lenCode(lenCode), .ilvOrder(ilvOrder), .nextCol(dpCol), .atEnd(atEnd)
  );

  assign colAddr = busy ? dpCol : '0;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int unsigned COL_W      = 8,
  parameter int unsigned LEN_W      = 3,
  parameter int unsigned MAX_LOG_BL = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmdValid,
  input logic [COL_W-1:0] startCol,
  input logic [LEN_W-1:0] lenCode,
  input logic             ilvOrder,
  input logic             stopCmd,
  input logic [COL_W-1:0] colAddr,
  input logic             lastBeat,
  input logic             busy
);
  logic legalCmd;
  logic fullMode;

  assign legalCmd = cmdValid &&
    ((lenCode <= LEN_W'(MAX_LOG_BL)) || ((lenCode == LEN_W'(7)) && !ilvOrder));

  always_ff @(posedge clk) begin
    if (!rst_n)        fullMode <= 1'b0;
    else if (legalCmd) fullMode <= (lenCode == LEN_W'(7));
  end

  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legalCmd |=> busy && colAddr == $past(startCol));

  // R5
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat && !cmdValid |=> !busy);

  // R6
  full_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fullMode && busy && $past(busy) && !$past(cmdValid) |->
      colAddr == COL_W'($past(colAddr) + 1'b1));

  // R6
  full_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fullMode |-> !lastBeat);

  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopCmd && !cmdValid |=> !busy && colAddr == '0);

  // R9
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmdValid && !legalCmd |=> !busy);

  // R10
  last_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat |-> busy);
endmodule

bind burst_col_gen burst_col_gen_chk #(
  .COL_W(COL_W), .LEN_W(LEN_W), .MAX_LOG_BL(MAX_LOG_BL)
) i_burst_col_gen_chk (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .startCol(startCol),
  .lenCode(lenCode), .ilvOrder(ilvOrder), .stopCmd(stopCmd),
  .colAddr(colAddr), .lastBeat(lastBeat), .busy(busy)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       ilvOrder = 1'b0;
  logic       stopCmd = 1'b0;
  logic [7:0] colAddr;
  logic       lastBeat;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_col_gen i_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .startCol(startCol),
    .lenCode(lenCode), .ilvOrder(ilvOrder), .stopCmd(stopCmd),
    .colAddr(colAddr), .lastBeat(lastBeat), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] s, input logic [2:0] code, input logic typ);
    cmdValid = 1'b1; startCol = s; lenCode = code; ilvOrder = typ;
  endtask

  function automatic logic [7:0] expCol(input logic [7:0] s, input int bl,
                                        input logic typ, input int n);
    logic [7:0] m;
    m = 8'(bl - 1);
    if (typ) return s ^ 8'(n);
    return (s & ~m) | (8'(int'(s) + n) & m);
  endfunction

  task automatic runBurst(input logic [7:0] s, input logic [2:0] code, input logic typ);
    int bl;
    bl = 1 << code;
    @(negedge clk); issue(s, code, typ);
    @(negedge clk); cmdValid = 1'b0;
    for (int n = 0; n < bl; n++) begin
      chk("R2", busy, 1);
      chk(typ ? "R4" : "R3", colAddr, expCol(s, bl, typ, n));
      chk("R5", lastBeat, (n == bl - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R5", busy, 0);
    chk("R5", colAddr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", busy, 0); chk("R1", lastBeat, 0); chk("R1", colAddr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", busy, 0); chk("R1", colAddr, 0);

    // R3 R4 R5: sweep of every start column, fixed length and order
    for (int code = 0; code < 4; code++)
      for (int typ = 0; typ < 2; typ++)
        for (int s = 0; s < 256; s++)
          runBurst(8'(s), 3'(code), typ[0]);

    // R6 full page wrap and R7 stop
    @(negedge clk); issue(8'd250, 3'd7, 1'b0);
    @(negedge clk); cmdValid = 1'b0;
    for (int n = 0; n < 300; n++) begin
      chk("R6", colAddr, (250 + n) % 256);
      chk("R6", lastBeat, 0);
      chk("R6", busy, 1);
      if (n < 299) @(negedge clk);
    end
    stopCmd = 1'b1;
    @(negedge clk); stopCmd = 1'b0;
    chk("R7", busy, 0); chk("R7", colAddr, 0); chk("R10", lastBeat, 0);

    // R7 stop in the middle of an 8-beat burst
    @(negedge clk); issue(8'h13, 3'd3, 1'b0);
    @(negedge clk); cmdValid = 1'b0;
    @(negedge clk); chk("R3", colAddr, 8'h14); stopCmd = 1'b1;
    @(negedge clk); stopCmd = 1'b0; chk("R7", busy, 0);

    // R8 interrupt mid-burst with a different configuration
    @(negedge clk); issue(8'h05, 3'd3, 1'b0);
    @(negedge clk); cmdValid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3", colAddr, 8'h07);
    issue(8'h41, 3'd1, 1'b1);
    @(negedge clk); cmdValid = 1'b0;
    chk("R8", colAddr, 8'h41); chk("R8", lastBeat, 0);
    @(negedge clk);
    chk("R8", colAddr, 8'h40); chk("R8", lastBeat, 1);
    @(negedge clk); chk("R8", busy, 0);

    // R8 interrupt on the final beat, together with a stop
    @(negedge clk); issue(8'h20, 3'd1, 1'b0);
    @(negedge clk); cmdValid = 1'b0;
    @(negedge clk); chk("R5", lastBeat, 1);
    issue(8'h9C, 3'd2, 1'b0); stopCmd = 1'b1;
    @(negedge clk); cmdValid = 1'b0; stopCmd = 1'b0;
    chk("R8", busy, 1); chk("R8", colAddr, 8'h9C);
    @(negedge clk); chk("R8", colAddr, 8'h9D);
    @(negedge clk); chk("R8", colAddr, 8'h9E);
    @(negedge clk); chk("R8", colAddr, 8'h9F); chk("R8", lastBeat, 1);
    @(negedge clk); chk("R8", busy, 0);

    // R9 illegal commands while idle
    issue(8'h10, 3'd7, 1'b1);
    @(negedge clk); cmdValid = 1'b0;
    chk("R9", busy, 0); chk("R9", colAddr, 0);
    for (int c = 4; c < 7; c++) begin
      issue(8'h33, 3'(c), 1'b0);
      @(negedge clk); cmdValid = 1'b0;
      chk("R9", busy, 0);
    end

    // R9 illegal commands during a burst leave it running
    issue(8'h80, 3'd2, 1'b1);
    @(negedge clk); cmdValid = 1'b0;
    chk("R4", colAddr, 8'h80);
    issue(8'h11, 3'd5, 1'b0);
    @(negedge clk); cmdValid = 1'b0;
    chk("R9", colAddr, 8'h81);
    issue(8'h22, 3'd7, 1'b1);
    @(negedge clk); cmdValid = 1'b0;
    chk("R9", colAddr, 8'h82);
    @(negedge clk);
    chk("R9", colAddr, 8'h83); chk("R9", lastBeat, 1);
    @(negedge clk); chk("R9", busy, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule